// File: doc/BRIEF.md
# CPU Exception Entry Controller

This block holds the system-control state that a small 32-bit in-order CPU uses when it leaves normal execution: the status word, the cause word, the two saved-PC words (one for ordinary traps, one for resets and non-maskable interrupts), the TLB replacement index and the TLB wired boundary. It takes requests from the rest of the core and turns them into a redirect. The requests are cold reset, soft reset, NMI, and a general trap with a 5-bit reason code and a vector offset select. The core also supplies the PC of the instruction concerned and a flag saying that this instruction sits in a branch delay slot.

The block picks the most urgent request and updates the control words. It then pulses a pipeline flush, holds a stall for a fixed number of dead cycles, and finally pulses a fetch-resume strobe while it presents the target address. All request pins are single-cycle pulses sampled on the rising clock edge. A request of lower rank that arrives in the same cycle as a higher one is dropped, not queued. A simple write port lets the status word and the trap PC word be loaded directly. It is meant for setup, and any entry in the same cycle overrides it.

Top module: `exc_entry_ctrl`

## Requirements
- R1: Rank is cold reset, then soft reset, then NMI, then general trap. Only the highest request in a cycle takes effect, and a general trap that arrives with any reset or NMI leaves `cause_q` and `epc_q` unchanged.
- R2: Cold reset loads `random_q` with TLB_ENTRIES-1 (47 by default) and clears `wired_q`. It also drives `cache_tlb_rst` high for exactly the one cycle after the entry edge. Soft reset and NMI do neither.
- R3: On any reset or NMI, `err_epc_q` receives `pc_in`, or `pc_in` minus 4 when `in_delay_slot` is high.
- R4: On any reset or NMI, status bit 22 (boot vectors) and bit 2 (error level) are set. Bit 20 (soft-reset flag) is set for soft reset or NMI and cleared for cold reset. All other status bits keep their values.
- R5: Reset and NMI entry redirects to 0xBFC00000.
- R6: General trap entry writes `cause_q` as follows: the reason code goes in bits [6:2], bit 31 copies `in_delay_slot`, bits [15:8] keep their old value, and every other bit is zero.
- R7: General trap entry copies `pc_in` (minus 4 in a delay slot) into `epc_q` and sets status bit 1 (trap level) only if bit 1 was clear. If bit 1 was already set, `epc_q` is unchanged.
- R8: The trap target is 0xBFC00200 plus the offset when status bit 22 is 1, and 0x80000000 plus the offset when it is 0. The offset is 0x000 for `vec_sel`=0, 0x080 for 1, and 0x180 for 2 or 3.
- R9: Every entry raises `flush` for exactly the one cycle after the entry edge. `kernel_mode` equals status bit 2 OR status bit 1.
- R10: After an entry edge, `stall` is high for exactly 5 cycles. In the following cycle `fetch_go` is high for one cycle with `stall` low and `redirect_pc` holding the target.
- R11: `rst_n` low clears every control word, `stall`, `flush` and `fetch_go`. With no request, all control words hold their values.
- R12: `sw_wr_status` and `sw_wr_epc` load `sw_wdata` into the status word or the trap PC word when no entry happens in that cycle. They are ignored for both words when an entry happens.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low hardware reset |
| cold_rst_req | input | 1 | Cold reset request pulse |
| soft_rst_req | input | 1 | Soft reset request pulse |
| nmi_req | input | 1 | Non-maskable interrupt request pulse |
| exc_req | input | 1 | General trap request pulse |
| exc_code | input | 5 | Trap reason code |
| vec_sel | input | 2 | Trap vector offset select |
| pc_in | input | 32 | PC of the instruction concerned |
| in_delay_slot | input | 1 | Instruction is in a branch delay slot |
| sw_wr_status | input | 1 | Direct write of status word |
| sw_wr_epc | input | 1 | Direct write of trap PC word |
| sw_wdata | input | 32 | Data for direct writes |
| flush | output | 1 | One-cycle pipeline flush |
| stall | output | 1 | Dead-cycle stall |
| fetch_go | output | 1 | Fetch resumes at redirect_pc |
| redirect_pc | output | 32 | Target address of last entry |
| kernel_mode | output | 1 | Core is in kernel mode |
| cache_tlb_rst | output | 1 | Reset strobe for caches and TLB |
| status_q | output | 32 | Status word |
| cause_q | output | 32 | Cause word |
| epc_q | output | 32 | Trap saved PC |
| err_epc_q | output | 32 | Reset/NMI saved PC |
| random_q | output | 6 | TLB replacement index |
| wired_q | output | 6 | TLB wired boundary |

## Verification
The bench raises a trap while the trap-level bit is already set. A design that ignores the gate would overwrite the saved PC and lose the first trap's return point. Delay-slot entries check that both saved-PC words step back by one instruction and that the cause top bit follows. A design that skips this would return into the branch's shadow. Cycles with several requests at once, and a trap that coincides with a direct write, show up a wrong rank as a changed cause word or a software value that leaks through. The stall window is counted cycle by cycle, so one dead cycle too many or too few moves the resume strobe and is reported.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;
  localparam int ST_EXL = 1;
  localparam int ST_ERL = 2;
  localparam int ST_SR  = 20;
  localparam int ST_BEV = 22;
  localparam int CA_BD  = 31;

  localparam logic [31:0] RESET_VEC = 32'hBFC0_0000;
  localparam logic [31:0] BOOT_BASE = 32'hBFC0_0200;
  localparam logic [31:0] NORM_BASE = 32'h8000_0000;

  typedef enum logic [2:0] {
    K_NONE = 3'd0,
    K_COLD = 3'd1,
    K_SOFT = 3'd2,
    K_NMI  = 3'd3,
    K_EXC  = 3'd4
  } entry_kind_e;
endpackage

// File: rtl/exc_arbiter.sv
module exc_arbiter
  import exc_entry_pkg::*;
(
  input  logic        cold_i,
  input  logic        soft_i,
  input  logic        nmi_i,
  input  logic        exc_i,
  output entry_kind_e kind_o
);
  always_comb begin
    if (cold_i)      kind_o = K_COLD;
    else if (soft_i) kind_o = K_SOFT;
    else if (nmi_i)  kind_o = K_NMI;
    else if (exc_i)  kind_o = K_EXC;
    else             kind_o = K_NONE;
  end
endmodule

// File: rtl/exc_target.sv
module exc_target
  import exc_entry_pkg::*;
(
  input  entry_kind_e kind_i,
  input  logic        bev_i,
  input  logic [1:0]  vec_sel_i,
  input  logic [31:0] pc_i,
  input  logic        ds_i,
  output logic [31:0] saved_pc_o,
  output logic [31:0] target_o
);
  logic [31:0] offset;

  always_comb begin
    case (vec_sel_i)
      2'd0:    offset = 32'h000;
      2'd1:    offset = 32'h080;
      default: offset = 32'h180;
    endcase
  end

  assign saved_pc_o = ds_i ? (pc_i - 32'd4) : pc_i;

  always_comb begin
    if (kind_i == K_EXC)
      target_o = (bev_i ? BOOT_BASE : NORM_BASE) + offset;
    else
      target_o = RESET_VEC;
  end
endmodule

// File: rtl/exc_dead_timer.sv
module exc_dead_timer #(
  parameter int DEAD_CYCLES = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic stall_o,
  output logic go_o
);
  localparam int CW = $clog2(DEAD_CYCLES + 1);
  localparam logic [CW-1:0] LOAD = CW'(DEAD_CYCLES);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      go_o <= 1'b0;
    end else begin
      go_o <= (cnt == CW'(1)) && !start_i;
      if (start_i)        cnt <= LOAD;
      else if (cnt != '0) cnt <= cnt - CW'(1);
    end
  end

  assign stall_o = (cnt != '0);
endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
  import exc_entry_pkg::*;
#(
  parameter int TLB_ENTRIES = 48,
  parameter int DEAD_CYCLES = 5,
  parameter int RND_W       = $clog2(TLB_ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cold_rst_req,
  input  logic             soft_rst_req,
  input  logic             nmi_req,
  input  logic             exc_req,
  input  logic [4:0]       exc_code,
  input  logic [1:0]       vec_sel,
  input  logic [31:0]      pc_in,
  input  logic             in_delay_slot,
  input  logic             sw_wr_status,
  input  logic             sw_wr_epc,
  input  logic [31:0]      sw_wdata,
  output logic             flush,
  output logic             stall,
  output logic             fetch_go,
  output logic [31:0]      redirect_pc,
  output logic             kernel_mode,
  output logic             cache_tlb_rst,
  output logic [31:0]      status_q,
  output logic [31:0]      cause_q,
  output logic [31:0]      epc_q,
  output logic [31:0]      err_epc_q,
  output logic [RND_W-1:0] random_q,
  output logic [RND_W-1:0] wired_q
);
  localparam logic [RND_W-1:0] RND_TOP = RND_W'(TLB_ENTRIES - 1);

  entry_kind_e kind;
  logic [31:0] saved_pc, target;
  logic        entry, is_rst;

  exc_arbiter u_arb (
    .cold_i (cold_rst_req),
    .soft_i (soft_rst_req),
    .nmi_i  (nmi_req),
    .exc_i  (exc_req),
    .kind_o (kind)
  );

  exc_target u_tgt (
    .kind_i     (kind),
    .bev_i      (status_q[ST_BEV]),
    .vec_sel_i  (vec_sel),
    .pc_i       (pc_in),
    .ds_i       (in_delay_slot),
    .saved_pc_o (saved_pc),
    .target_o   (target)
  );

  exc_dead_timer #(.DEAD_CYCLES(DEAD_CYCLES)) u_tmr (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (entry),
    .stall_o (stall),
    .go_o    (fetch_go)
  );

  assign entry  = (kind != K_NONE);
  assign is_rst = (kind == K_COLD) || (kind == K_SOFT) || (kind == K_NMI);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q      <= '0;
      cause_q       <= '0;
      epc_q         <= '0;
      err_epc_q     <= '0;
      random_q      <= '0;
      wired_q       <= '0;
      flush         <= 1'b0;
      cache_tlb_rst <= 1'b0;
      redirect_pc   <= '0;
    end else begin
      flush         <= entry;
      cache_tlb_rst <= (kind == K_COLD);
      if (entry) redirect_pc <= target;

      if (is_rst) begin
        err_epc_q            <= saved_pc;
        status_q[ST_BEV]     <= 1'b1;
        status_q[ST_ERL]     <= 1'b1;
        status_q[ST_SR]      <= (kind != K_COLD);
        if (kind == K_COLD) begin
          random_q <= RND_TOP;
          wired_q  <= '0;
        end
      end else if (kind == K_EXC) begin
        cause_q <= {in_delay_slot, 15'b0, cause_q[15:8], 1'b0, exc_code, 2'b00};
        if (!status_q[ST_EXL]) begin
          epc_q            <= saved_pc;
          status_q[ST_EXL] <= 1'b1;
        end
      end else begin
        if (sw_wr_status) status_q <= sw_wdata;
        if (sw_wr_epc)    epc_q    <= sw_wdata;
      end
    end
  end

  assign kernel_mode = status_q[ST_ERL] | status_q[ST_EXL];
endmodule

// File: rtl/exc_entry_chk.sv
module exc_entry_chk #(
  parameter int TLB_ENTRIES = 48,
  parameter int RND_W       = $clog2(TLB_ENTRIES)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             flush,
  input logic             stall,
  input logic             fetch_go,
  input logic             kernel_mode,
  input logic             cache_tlb_rst,
  input logic [RND_W-1:0] random_q,
  input logic [RND_W-1:0] wired_q
);
  // R9
  flush_kernel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> (stall && kernel_mode));

  // R10
  stall_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stall) |-> flush);

  // R10
  resume_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_go |-> (!stall && !flush));

  // R10
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (stall || flush));

  // R2
  cold_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cache_tlb_rst |-> (flush && random_q == RND_W'(TLB_ENTRIES - 1) && wired_q == '0));
endmodule

bind exc_entry_ctrl exc_entry_chk #(.TLB_ENTRIES(TLB_ENTRIES), .RND_W(RND_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .flush         (flush),
  .stall         (stall),
  .fetch_go      (fetch_go),
  .kernel_mode   (kernel_mode),
  .cache_tlb_rst (cache_tlb_rst),
  .random_q      (random_q),
  .wired_q       (wired_q)
);

// File: tb/exc_entry_ctrl_tb.sv
module exc_entry_ctrl_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cold_rst_req = 0, soft_rst_req = 0, nmi_req = 0, exc_req = 0;
  logic [4:0] exc_code = '0;
  logic [1:0] vec_sel = '0;
  logic [31:0] pc_in = '0;
  logic in_delay_slot = 0;
  logic sw_wr_status = 0, sw_wr_epc = 0;
  logic [31:0] sw_wdata = '0;
  logic flush, stall, fetch_go, kernel_mode, cache_tlb_rst;
  logic [31:0] redirect_pc, status_q, cause_q, epc_q, err_epc_q;
  logic [5:0] random_q, wired_q;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  exc_entry_ctrl u_dut (
    .clk(clk), .rst_n(rst_n),
    .cold_rst_req(cold_rst_req), .soft_rst_req(soft_rst_req),
    .nmi_req(nmi_req), .exc_req(exc_req), .exc_code(exc_code),
    .vec_sel(vec_sel), .pc_in(pc_in), .in_delay_slot(in_delay_slot),
    .sw_wr_status(sw_wr_status), .sw_wr_epc(sw_wr_epc), .sw_wdata(sw_wdata),
    .flush(flush), .stall(stall), .fetch_go(fetch_go),
    .redirect_pc(redirect_pc), .kernel_mode(kernel_mode),
    .cache_tlb_rst(cache_tlb_rst), .status_q(status_q), .cause_q(cause_q),
    .epc_q(epc_q), .err_epc_q(err_epc_q), .random_q(random_q), .wired_q(wired_q)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic clear_in();
    cold_rst_req = 0; soft_rst_req = 0; nmi_req = 0; exc_req = 0;
    sw_wr_status = 0; sw_wr_epc = 0; in_delay_slot = 0;
  endtask

  // drive at negedge, one edge, clear at next negedge (regs then visible)
  task automatic step();
    @(negedge clk);
    clear_in();
  endtask

  task automatic wr_status(input logic [31:0] v);
    @(negedge clk);
    sw_wr_status = 1; sw_wdata = v;
    step();
  endtask

  task automatic settle();
    repeat (7) @(negedge clk);
  endtask

  task automatic t_reset_state();
    @(negedge clk);
    chk("R11 status", status_q, 0);
    chk("R11 cause", cause_q, 0);
    chk("R11 epc", epc_q, 0);
    chk("R11 errepc", err_epc_q, 0);
    chk("R11 stall/flush/go", {29'b0, stall, flush, fetch_go}, 0);
    chk("R9 kernel off", kernel_mode, 0);
  endtask

  task automatic t_cold_timing();
    @(negedge clk);
    cold_rst_req = 1; pc_in = 32'h1234;
    step();
    chk("R3 errepc", err_epc_q, 32'h1234);
    chk("R4 status cold", status_q, 32'h0040_0004);
    chk("R2 random", random_q, 47);
    chk("R2 wired", wired_q, 0);
    chk("R2 strobe", cache_tlb_rst, 1);
    chk("R9 flush", flush, 1);
    chk("R9 kernel", kernel_mode, 1);
    chk("R5 vector", redirect_pc, 32'hBFC0_0000);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk("R10 stall held", {stall, fetch_go, flush}, 3'b100);
      chk("R2 strobe one cycle", cache_tlb_rst, 0);
    end
    @(negedge clk);
    chk("R10 resume", {stall, fetch_go}, 2'b01);
    chk("R10 resume pc", redirect_pc, 32'hBFC0_0000);
    @(negedge clk);
    chk("R10 go one cycle", fetch_go, 0);
  endtask

  task automatic t_soft_ds();
    wr_status(32'h0000_FF00);
    @(negedge clk);
    soft_rst_req = 1; pc_in = 32'h2000; in_delay_slot = 1;
    step();
    chk("R3 errepc ds", err_epc_q, 32'h1FFC);
    chk("R4 status soft", status_q, 32'h0050_FF04);
    chk("R2 no strobe soft", cache_tlb_rst, 0);
    settle();
  endtask

  task automatic t_nmi();
    wr_status(32'h0);
    @(negedge clk);
    nmi_req = 1; pc_in = 32'h3000;
    step();
    chk("R4 status nmi", status_q, 32'h0050_0004);
    chk("R3 errepc nmi", err_epc_q, 32'h3000);
    chk("R5 nmi vector", redirect_pc, 32'hBFC0_0000);
    settle();
  endtask

  task automatic t_exc();
    wr_status(32'h0040_0000);
    @(negedge clk);
    exc_req = 1; exc_code = 5'd12; vec_sel = 2'd2; pc_in = 32'h4000; in_delay_slot = 1;
    step();
    chk("R6 cause ds", cause_q, 32'h8000_0030);
    chk("R7 epc ds", epc_q, 32'h3FFC);
    chk("R7 exl set", status_q, 32'h0040_0002);
    chk("R8 bev1 sel2", redirect_pc, 32'hBFC0_0380);
    chk("R9 flush exc", flush, 1);
    settle();
    @(negedge clk);
    exc_req = 1; exc_code = 5'd8; vec_sel = 2'd1; pc_in = 32'h5000;
    step();
    chk("R6 cause no ds", cause_q, 32'h0000_0020);
    chk("R7 epc kept nested", epc_q, 32'h3FFC);
    chk("R8 bev1 sel1", redirect_pc, 32'hBFC0_0280);
    settle();
    wr_status(32'h0);
    chk("R9 kernel cleared", kernel_mode, 0);
    @(negedge clk);
    exc_req = 1; exc_code = 5'd4; vec_sel = 2'd0; pc_in = 32'h6000;
    step();
    chk("R7 epc fresh", epc_q, 32'h6000);
    chk("R8 bev0 sel0", redirect_pc, 32'h8000_0000);
    chk("R7 status", status_q, 32'h2);
    settle();
    @(negedge clk);
    exc_req = 1; exc_code = 5'd13; vec_sel = 2'd3; pc_in = 32'h6100;
    step();
    chk("R8 bev0 sel3", redirect_pc, 32'h8000_0180);
    settle();
  endtask

  task automatic t_priority();
    wr_status(32'h0);
    @(negedge clk);
    soft_rst_req = 1; exc_req = 1; exc_code = 5'd10; pc_in = 32'h7000;
    step();
    chk("R1 cause untouched", cause_q, 32'h0000_0034);
    chk("R1 epc untouched", epc_q, 32'h6000);
    chk("R1 errepc", err_epc_q, 32'h7000);
    chk("R1 status soft wins", status_q, 32'h0050_0004);
    settle();
    @(negedge clk);
    cold_rst_req = 1; nmi_req = 1; pc_in = 32'h7100;
    step();
    chk("R1 cold over nmi", status_q, 32'h0040_0004);
    chk("R1 cold strobe", cache_tlb_rst, 1);
    settle();
  endtask

  task automatic t_sw_conflict();
    wr_status(32'h0);
    @(negedge clk);
    exc_req = 1; exc_code = 5'd13; vec_sel = 2'd2; pc_in = 32'h8000;
    sw_wr_status = 1; sw_wr_epc = 1; sw_wdata = 32'hDEAD_0000;
    step();
    chk("R12 epc entry wins", epc_q, 32'h8000);
    chk("R12 status entry wins", status_q, 32'h2);
    settle();
    chk("R11 hold cause", cause_q, 32'h0000_0034);
    chk("R11 hold epc", epc_q, 32'h8000);
    chk("R11 hold errepc", err_epc_q, 32'h7100);
    @(negedge clk);
    sw_wr_epc = 1; sw_wdata = 32'h1111_0000;
    step();
    chk("R12 epc write", epc_q, 32'h1111_0000);
    chk("R12 status not written", status_q, 32'h2);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        t_reset_state();
        t_cold_timing();
        t_soft_ds();
        t_nmi();
        t_exc();
        t_priority();
        t_sw_conflict();
      end
      begin
        repeat (5000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    disable fork;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule